// File: doc/BRIEF.md
# Processor Bus Glue with UART Wait States

This block decodes the upper address lines of a small processor system that has an 8-bit data bus. It drives active-low selects for a 32 KB boot ROM, a 32 KB static RAM and a serial UART. It also returns the data-transfer acknowledge to the processor. Each decoded region is 32 KB wide, so only address bits 19..15 reach the block. Every select is qualified by the address strobe.

ROM, RAM, the LED register and unmapped addresses are acknowledged at once. The UART is slow and needs wait states. A saturating counter sits at a preset while the UART is not addressed. During a UART cycle it counts up once per clock, and the acknowledge goes low only when the counter reaches its top value.

A single write-only byte register holds the state of eight LEDs. It is loaded from the data bus. There is no data flow with back-pressure here: the processor's strobe and acknowledge are the only handshake, and all pins are plain level signals.

Top module: `sysbus_glue`

## Requirements
- R1: With `as_n` low and address bits 19..15 equal to 5'b00000 (0x00000-0x07FFF), `rom_cs_n` is low and the other selects are high.
- R2: With `as_n` low and address bits 19..15 equal to 5'b11100 (0xE0000-0xE7FFF), `ram_cs_n` is low and the other selects are high.
- R3: With `as_n` low and address bits 19..15 equal to 5'b11110 (0xF0000-0xF7FFF), `uart_cs_n` is low and the other selects are high.
- R4: At most one select is low at any time. While `as_n` is high, all selects and `dtack_n` are high.
- R5: Any cycle that does not address the UART gets `dtack_n` low in the same clock period in which `as_n` goes low. This covers ROM, RAM, the LED register and unmapped addresses.
- R6: In a UART cycle, `dtack_n` stays high for exactly WAIT_CLKS (default 3) rising clock edges with `as_n` low. It goes low after the last of these edges and stays low until `as_n` rises.
- R7: A rising edge that samples `as_n` high returns the counter to its preset. Back-to-back UART cycles separated by a single such edge each get the full WAIT_CLKS wait.
- R8: The LED register decodes address bits 19..15 equal to 5'b11111 (0xF8000-0xFFFFF). It captures `data_in` on a rising edge where `as_n`, `ds_n` and `rw` are all low. `led` shows the stored byte, with bit i of the data bus driving `led[i]`.
- R9: The LED register keeps its value on read cycles (`rw` high), on writes with `ds_n` high, and on writes to any other address.
- R10: After reset, `led` is 8'h00 and the wait counter is at its preset, so the first UART cycle gets the full wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_hi | input | 5 | Address bits 19..15 |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | High for read, low for write |
| data_in | input | 8 | Processor data bus |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| ram_cs_n | output | 1 | Static RAM select, active low |
| uart_cs_n | output | 1 | UART select, active low |
| dtack_n | output | 1 | Data-transfer acknowledge, active low |
| led | output | 8 | LED register contents |

## Verification
The hardest case to reach is the counter reload between two UART cycles. The address strobe is high for only one rising edge in that case. A design that waits for several idle clocks, or one that only partly reloads, fails only there. The driver starts each new cycle exactly one edge after it releases the strobe. A monitor counts the rising edges seen while the strobe is low up to the acknowledge, and compares that count with the queued expectation for every cycle. The decode boundaries just inside and outside each region are driven in the same way.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int NREG = 4;
  localparam int RG_ROM  = 0;
  localparam int RG_RAM  = 1;
  localparam int RG_UART = 2;
  localparam int RG_LED  = 3;

  // region tag = address bits above the 32 KB window
  function automatic logic [7:0] region_tag(input int idx);
    case (idx)
      RG_ROM:  region_tag = 8'h00;
      RG_RAM:  region_tag = 8'h1C;
      RG_UART: region_tag = 8'h1E;
      default: region_tag = 8'h1F;
    endcase
  endfunction
endpackage

// File: rtl/addr_decoder.sv
module addr_decoder #(
  parameter int TAG_W = 5
) (
  input  logic [TAG_W-1:0]          tag,
  input  logic                      as_n,
  output logic [glue_pkg::NREG-1:0] hit
);
  for (genvar i = 0; i < glue_pkg::NREG; i++) begin : g_reg
    localparam logic [TAG_W-1:0] MATCH = TAG_W'(glue_pkg::region_tag(i));
    assign hit[i] = !as_n && (tag == MATCH);
  end
endmodule

// File: rtl/wait_counter.sv
module wait_counter #(
  parameter int CNT_W     = 4,
  parameter int WAIT_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_sel,
  output logic done
);
  localparam logic [CNT_W-1:0] TOP    = '1;
  localparam logic [CNT_W-1:0] PRESET = TOP - CNT_W'(WAIT_CLKS);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= PRESET;
    else if (!slow_sel)    cnt <= PRESET;
    else if (cnt != TOP)   cnt <= cnt + 1'b1;
  end

  assign done = (cnt == TOP);
endmodule

// File: rtl/led_latch.sv
module led_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= d;
  end
endmodule

// File: rtl/sysbus_glue.sv
module sysbus_glue #(
  parameter int ADDR_W    = 20,
  parameter int SPAN_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 4,
  parameter int WAIT_CLKS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-SPAN_W-1:0] a_hi,
  input  logic                     as_n,
  input  logic                     ds_n,
  input  logic                     rw,
  input  logic [DATA_W-1:0]        data_in,
  output logic                     rom_cs_n,
  output logic                     ram_cs_n,
  output logic                     uart_cs_n,
  output logic                     dtack_n,
  output logic [DATA_W-1:0]        led
);
  localparam int TAG_W = ADDR_W - SPAN_W;

  logic [glue_pkg::NREG-1:0] hit;
  logic                      wait_done;
  logic                      led_wr;

  addr_decoder #(.TAG_W(TAG_W)) u_dec (
    .tag (a_hi),
    .as_n(as_n),
    .hit (hit)
  );

  wait_counter #(.CNT_W(CNT_W), .WAIT_CLKS(WAIT_CLKS)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .slow_sel(hit[glue_pkg::RG_UART]),
    .done    (wait_done)
  );

  assign led_wr = hit[glue_pkg::RG_LED] && !ds_n && !rw;

  led_latch #(.DATA_W(DATA_W)) u_led (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(led_wr),
    .d    (data_in),
    .q    (led)
  );

  assign rom_cs_n  = !hit[glue_pkg::RG_ROM];
  assign ram_cs_n  = !hit[glue_pkg::RG_RAM];
  assign uart_cs_n = !hit[glue_pkg::RG_UART];

  always_comb begin
    if (as_n)                         dtack_n = 1'b1;
    else if (hit[glue_pkg::RG_UART])  dtack_n = !wait_done;
    else                              dtack_n = 1'b0;
  end
endmodule

// File: rtl/glue_checker.sv
module glue_checker #(
  parameter int TAG_W     = 5,
  parameter int DATA_W    = 8,
  parameter int WAIT_CLKS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TAG_W-1:0]  a_hi,
  input logic              as_n,
  input logic              ds_n,
  input logic              rw,
  input logic              rom_cs_n,
  input logic              ram_cs_n,
  input logic              uart_cs_n,
  input logic              dtack_n,
  input logic [DATA_W-1:0] led
);
  logic [7:0] slow_edges;
  logic       led_write;

  assign led_write = !as_n && !ds_n && !rw && (a_hi == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     slow_edges <= '0;
    else if (uart_cs_n)             slow_edges <= '0;
    else if (slow_edges != 8'hFF)   slow_edges <= slow_edges + 1'b1;
  end

  assert_one_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!rom_cs_n, !ram_cs_n, !uart_cs_n}));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (rom_cs_n && ram_cs_n && uart_cs_n && dtack_n));

  assert_fast_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && uart_cs_n) |-> !dtack_n);

  assert_no_early_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_cs_n && (int'(slow_edges) < WAIT_CLKS)) |-> dtack_n);

  assert_ack_after_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_cs_n && (int'(slow_edges) >= WAIT_CLKS)) |-> !dtack_n);

  assert_led_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !led_write |=> $stable(led));
endmodule

bind sysbus_glue glue_checker #(
  .TAG_W(ADDR_W - SPAN_W), .DATA_W(DATA_W), .WAIT_CLKS(WAIT_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .a_hi(a_hi), .as_n(as_n), .ds_n(ds_n), .rw(rw),
  .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .uart_cs_n(uart_cs_n),
  .dtack_n(dtack_n), .led(led)
);

// File: tb/sysbus_glue_tb.sv
module sysbus_glue_tb;
  localparam int WAITS = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] a_hi = '0;
  logic       as_n = 1'b1;
  logic       ds_n = 1'b1;
  logic       rw = 1'b1;
  logic [7:0] data_in = '0;
  logic       rom_cs_n, ram_cs_n, uart_cs_n, dtack_n;
  logic [7:0] led;

  int errs = 0;
  int checks = 0;

  typedef struct {
    string      req;
    logic [2:0] cs;
    int         waits;
  } exp_t;
  exp_t exp_q[$];

  int edges_low = 0;
  bit reported = 0;

  always #10 clk = ~clk;

  sysbus_glue u_dut (
    .clk(clk), .rst_n(rst_n), .a_hi(a_hi), .as_n(as_n), .ds_n(ds_n), .rw(rw),
    .data_in(data_in), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
    .uart_cs_n(uart_cs_n), .dtack_n(dtack_n), .led(led)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // edge counter for the monitor
  initial forever begin
    @(posedge clk);
    if (as_n) begin
      edges_low = 0;
      reported  = 0;
    end else begin
      edges_low++;
    end
  end

  // monitor: at the first acknowledged sample of a cycle, pop and compare
  initial forever begin
    @(negedge clk);
    if (!as_n && !dtack_n && !reported) begin
      reported = 1;
      if (exp_q.size() == 0) begin
        check("R4 unexpected ack", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.req, " selects"}, {29'd0, rom_cs_n, ram_cs_n, uart_cs_n},
              {29'd0, e.cs});
        check({e.req, " wait edges"}, edges_low, e.waits);
      end
    end
  end

  // driver: one bus cycle; cs order {rom,ram,uart}, active low
  task automatic bus_cycle(string req, logic [19:0] addr, logic rdwr, logic dsn,
                           logic [7:0] d, logic [2:0] exp_cs, int exp_w);
    exp_t e;
    e.req = req; e.cs = exp_cs; e.waits = exp_w;
    exp_q.push_back(e);
    @(posedge clk); #1;
    a_hi = addr[19:15]; rw = rdwr; data_in = d; as_n = 1'b0; ds_n = dsn;
    do @(negedge clk); while (dtack_n);
    @(posedge clk); #1;
    as_n = 1'b1; ds_n = 1'b1; rw = 1'b1;
  endtask

  task automatic idle_check(string req);
    @(negedge clk);
    check({req, " idle selects+ack"},
          {28'd0, rom_cs_n, ram_cs_n, uart_cs_n, dtack_n}, 32'hF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 led at reset", led, 8'h00);
    check("R4 selects in reset", {29'd0, rom_cs_n, ram_cs_n, uart_cs_n}, 32'h7);
    rst_n = 1'b1;

    // R10/R6: first UART cycle after reset gets the full wait
    bus_cycle("R6 uart low", 20'hF0000, 1'b1, 1'b0, 8'h00, 3'b110, WAITS);
    idle_check("R4");
    bus_cycle("R1 rom base", 20'h00000, 1'b1, 1'b0, 8'h00, 3'b011, 0);
    bus_cycle("R1 rom top", 20'h07FFF, 1'b1, 1'b0, 8'h00, 3'b011, 0);
    bus_cycle("R5 unmapped above rom", 20'h08000, 1'b1, 1'b0, 8'h00, 3'b111, 0);
    bus_cycle("R2 ram base", 20'hE0000, 1'b0, 1'b0, 8'h11, 3'b101, 0);
    bus_cycle("R2 ram top", 20'hE7FFF, 1'b1, 1'b0, 8'h00, 3'b101, 0);
    bus_cycle("R5 unmapped above ram", 20'hE8000, 1'b1, 1'b0, 8'h00, 3'b111, 0);
    bus_cycle("R5 unmapped below uart", 20'hEFFFF, 1'b1, 1'b0, 8'h00, 3'b111, 0);
    bus_cycle("R3 uart top", 20'hF7FFF, 1'b0, 1'b0, 8'h42, 3'b110, WAITS);
    // R7: back-to-back UART cycles with one idle edge between
    bus_cycle("R7 uart first", 20'hF0001, 1'b1, 1'b0, 8'h00, 3'b110, WAITS);
    bus_cycle("R7 uart second", 20'hF0002, 1'b1, 1'b0, 8'h00, 3'b110, WAITS);
    bus_cycle("R5 rom after uart", 20'h00004, 1'b1, 1'b0, 8'h00, 3'b011, 0);
    idle_check("R4 after uart");

    // LED register
    bus_cycle("R8 led write", 20'hF8000, 1'b0, 1'b0, 8'hA5, 3'b111, 0);
    @(negedge clk); check("R8 led value", led, 8'hA5);
    bus_cycle("R9 led read", 20'hF8001, 1'b1, 1'b0, 8'h3C, 3'b111, 0);
    @(negedge clk); check("R9 led after read", led, 8'hA5);
    bus_cycle("R9 led ds high", 20'hF8002, 1'b0, 1'b1, 8'h3C, 3'b111, 0);
    @(negedge clk); check("R9 led after ds_n high", led, 8'hA5);
    bus_cycle("R9 ram write", 20'hE0010, 1'b0, 1'b0, 8'hFF, 3'b101, 0);
    @(negedge clk); check("R9 led after ram write", led, 8'hA5);
    bus_cycle("R9 uart write", 20'hF0010, 1'b0, 1'b0, 8'h0F, 3'b110, WAITS);
    @(negedge clk); check("R9 led after uart write", led, 8'hA5);
    bus_cycle("R8 led write top", 20'hFFFFF, 1'b0, 1'b0, 8'h5A, 3'b111, 0);
    @(negedge clk); check("R8 led value top", led, 8'h5A);

    repeat (2) @(posedge clk);
    check("R4 all cycles acknowledged", exp_q.size(), 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule